// File: doc/BRIEF.md
# Register-Configurable Stream Loopback Switch

This block sits between the network port and the host DMA engine and routes two packet streams. It carries network receive traffic towards DMA receive, and DMA transmit traffic towards network transmit. Four small select registers on a 32-bit memory-mapped bus change the routing. The DMA receive sink can instead take the DMA transmit stream as a loopback, or a receive-side traffic source. The network transmit sink can instead take the network receive stream as a loopback, a transmit-side traffic source, or a frame-player input. Every stream is a valid/ready handshake carrying data plus start-of-frame and end-of-frame flags. Each of the two sinks is fed through a small FIFO.

The routing must only be changed while the affected sources are idle. The block does not guard against a frame being cut by a switch in mid-frame. A source that no path selects is held off with ready low, so no beat is ever dropped. When both paths select the same source, every beat is copied to both sinks and is accepted only when both have room. A build-time bypass parameter hard-wires network receive to DMA receive and DMA transmit to network transmit, and the registers then have no effect on routing.

Top module: `loop_switch`

## Requirements
- R1: After reset all four select registers read 0, both sink outputs have valid low, and the routing is network receive to DMA receive and DMA transmit to network transmit.
- R2: Only address bits [7:0] are decoded. The selector for DMA receive is at 0x00 (bit 0), the network transmit selector at 0x04 (bit 0), the receive-injection selector at 0x08 (bit 0) and the transmit-source selector at 0x0C (bits [1:0]). A write stores those low bits of the write data whatever the byte enables and the upper data bits are.
- R3: A read strobe gives read-valid high in the next cycle, with the addressed selector value zero-extended to 32 bits. Unmapped offsets read 0 and writes to them have no effect. The address-ready output is always high.
- R4: With the DMA receive selector at 0, the DMA receive sink gets the output of the receive-injection stage. With it at 1, the sink gets the DMA transmit stream.
- R5: The receive-injection stage passes network receive when its selector is 0 and the receive traffic source when it is 1.
- R6: With the network transmit selector at 0, the network transmit sink gets the output of the transmit-source stage. With it at 1, the sink gets the network receive stream.
- R7: The transmit-source stage passes DMA transmit for code 0, the transmit traffic source for code 1 and the frame player for code 2. Code 3 selects nothing, and the network transmit output then stays invalid.
- R8: Each sink is fed through a FIFO of FIFO_DEPTH entries. A beat accepted at a clock edge can appear at the sink from the next cycle on. Data, start and end flags and beat order are preserved, and a stalled sink output holds valid and data stable.
- R9: A source that neither path selects sees ready low. A selected source sees ready high only when every path selecting it has FIFO room, and each such FIFO then takes the beat.
- R10: With BYPASS set, network receive always goes to DMA receive and DMA transmit always goes to network transmit, whatever the register contents, and the three traffic-source inputs see ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Register address (bits [7:0] decoded) |
| bus_wdata | input | 32 | Register write data |
| bus_be | input | 4 | Byte enables (ignored) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_ardy | output | 1 | Address ready, always high |
| bus_rdata | output | 32 | Read data |
| bus_drdy | output | 1 | Read data valid |
| net_rx_valid | input | 1 | Network receive beat valid |
| net_rx_ready | output | 1 | Network receive ready |
| net_rx_data | input | DATA_W | Network receive data |
| net_rx_sof | input | 1 | Network receive start of frame |
| net_rx_eof | input | 1 | Network receive end of frame |
| dma_tx_valid | input | 1 | DMA transmit beat valid |
| dma_tx_ready | output | 1 | DMA transmit ready |
| dma_tx_data | input | DATA_W | DMA transmit data |
| dma_tx_sof | input | 1 | DMA transmit start of frame |
| dma_tx_eof | input | 1 | DMA transmit end of frame |
| rxsrc_valid | input | 1 | Receive traffic source valid |
| rxsrc_ready | output | 1 | Receive traffic source ready |
| rxsrc_data | input | DATA_W | Receive traffic source data |
| rxsrc_sof | input | 1 | Receive traffic source start of frame |
| rxsrc_eof | input | 1 | Receive traffic source end of frame |
| txsrc_valid | input | 1 | Transmit traffic source valid |
| txsrc_ready | output | 1 | Transmit traffic source ready |
| txsrc_data | input | DATA_W | Transmit traffic source data |
| txsrc_sof | input | 1 | Transmit traffic source start of frame |
| txsrc_eof | input | 1 | Transmit traffic source end of frame |
| play_valid | input | 1 | Frame player valid |
| play_ready | output | 1 | Frame player ready |
| play_data | input | DATA_W | Frame player data |
| play_sof | input | 1 | Frame player start of frame |
| play_eof | input | 1 | Frame player end of frame |
| dma_rx_valid | output | 1 | DMA receive sink valid |
| dma_rx_ready | input | 1 | DMA receive sink ready |
| dma_rx_data | output | DATA_W | DMA receive sink data |
| dma_rx_sof | output | 1 | DMA receive sink start of frame |
| dma_rx_eof | output | 1 | DMA receive sink end of frame |
| net_tx_valid | output | 1 | Network transmit sink valid |
| net_tx_ready | input | 1 | Network transmit sink ready |
| net_tx_data | output | DATA_W | Network transmit sink data |
| net_tx_sof | output | 1 | Network transmit sink start of frame |
| net_tx_eof | output | 1 | Network transmit sink end of frame |

## Verification
Three latencies apply, and each check samples in the cycle its result is due. Source ready is combinational on the registered selectors and FIFO fill level, so it is sampled in the same cycle, after a settle delay from the falling-edge drive. A beat accepted at a rising edge enters the FIFO there and can be seen at the sink from the following falling edge. Read data is checked at the falling edge after the edge that captured the strobe. Every source beat carries its source number and a sequence count, so a check at the sink tells which path it came through, in what order, and whether any beat was lost. A drain window after each routing setup lets the delivered count be compared with the accepted count.

// File: rtl/ls_pkg.sv
package ls_pkg;
  localparam int unsigned NUM_SRC = 5;

  typedef enum logic [2:0] {
    SRC_NETRX = 3'd0,
    SRC_DMATX = 3'd1,
    SRC_RXGEN = 3'd2,
    SRC_TXGEN = 3'd3,
    SRC_PLAY  = 3'd4,
    SRC_NONE  = 3'd5
  } ls_src_e;

  localparam logic [7:0] OFS_A = 8'h00;
  localparam logic [7:0] OFS_B = 8'h04;
  localparam logic [7:0] OFS_C = 8'h08;
  localparam logic [7:0] OFS_D = 8'h0C;

  typedef struct packed {
    logic       a;
    logic       b;
    logic       c;
    logic [1:0] d;
  } ls_sel_t;
endpackage

// File: rtl/ls_regs.sv
module ls_regs
  import ls_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  offs,
  input  logic [1:0]  wval,
  input  logic        wr,
  input  logic        rd,
  output logic [31:0] rdata,
  output logic        drdy,
  output ls_sel_t     sel
);
  ls_sel_t     sel_q, sel_d;
  logic [31:0] rdata_q, rdata_d;
  logic        drdy_q, drdy_d;

  always_comb begin
    sel_d = sel_q;
    if (wr) begin
      case (offs)
        OFS_A:   sel_d.a = wval[0];
        OFS_B:   sel_d.b = wval[0];
        OFS_C:   sel_d.c = wval[0];
        OFS_D:   sel_d.d = wval;
        default: sel_d = sel_q;
      endcase
    end
  end

  always_comb begin
    drdy_d  = rd;
    rdata_d = rdata_q;
    if (rd) begin
      case (offs)
        OFS_A:   rdata_d = {31'd0, sel_q.a};
        OFS_B:   rdata_d = {31'd0, sel_q.b};
        OFS_C:   rdata_d = {31'd0, sel_q.c};
        OFS_D:   rdata_d = {30'd0, sel_q.d};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      rdata_q <= '0;
      drdy_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      drdy_q <= drdy_d;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign sel   = sel_q;
  assign rdata = rdata_q;
  assign drdy  = drdy_q;
endmodule

// File: rtl/ls_fifo.sv
module ls_fifo #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] in_beat,
  output logic         room,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_beat
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop;

  assign pop = out_valid && out_ready;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= in_beat;
  end

  assign room      = (cnt_q != FULL);
  assign out_valid = (cnt_q != '0);
  assign out_beat  = mem[rp_q];
endmodule

// File: rtl/ls_route.sv
module ls_route
  import ls_pkg::*;
#(
  parameter int unsigned W      = 18,
  parameter bit          BYPASS = 1'b0
) (
  input  logic [NUM_SRC-1:0]         src_valid,
  input  logic [NUM_SRC-1:0][W-1:0]  src_beat,
  input  ls_sel_t                    sel,
  input  logic                       a_room,
  input  logic                       b_room,
  output logic [NUM_SRC-1:0]         src_ready,
  output logic                       a_push,
  output logic [W-1:0]               a_beat,
  output logic                       b_push,
  output logic [W-1:0]               b_beat
);
  ls_src_e pick_a, pick_b;

  generate
    if (BYPASS) begin : g_fixed
      logic unused_sel;
      assign unused_sel = ^sel;
      assign pick_a = SRC_NETRX;
      assign pick_b = SRC_DMATX;
    end else begin : g_regs
      always_comb begin
        if (sel.a)      pick_a = SRC_DMATX;
        else if (sel.c) pick_a = SRC_RXGEN;
        else            pick_a = SRC_NETRX;
        if (sel.b) pick_b = SRC_NETRX;
        else begin
          case (sel.d)
            2'd0:    pick_b = SRC_DMATX;
            2'd1:    pick_b = SRC_TXGEN;
            2'd2:    pick_b = SRC_PLAY;
            default: pick_b = SRC_NONE;
          endcase
        end
      end
    end
  endgenerate

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_rdy
    logic hit_a, hit_b;
    assign hit_a = (pick_a == ls_src_e'(s));
    assign hit_b = (pick_b == ls_src_e'(s));
    assign src_ready[s] = (hit_a || hit_b) && (!hit_a || a_room) && (!hit_b || b_room);
  end

  always_comb begin
    a_push = 1'b0;
    a_beat = '0;
    if (pick_a != SRC_NONE) begin
      a_push = src_valid[pick_a] && src_ready[pick_a];
      a_beat = src_beat[pick_a];
    end
    b_push = 1'b0;
    b_beat = '0;
    if (pick_b != SRC_NONE) begin
      b_push = src_valid[pick_b] && src_ready[pick_b];
      b_beat = src_beat[pick_b];
    end
  end
endmodule

// File: rtl/loop_switch.sv
module loop_switch
  import ls_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter bit          BYPASS     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              bus_ardy,
  output logic [31:0]       bus_rdata,
  output logic              bus_drdy,
  input  logic              net_rx_valid,
  output logic              net_rx_ready,
  input  logic [DATA_W-1:0] net_rx_data,
  input  logic              net_rx_sof,
  input  logic              net_rx_eof,
  input  logic              dma_tx_valid,
  output logic              dma_tx_ready,
  input  logic [DATA_W-1:0] dma_tx_data,
  input  logic              dma_tx_sof,
  input  logic              dma_tx_eof,
  input  logic              rxsrc_valid,
  output logic              rxsrc_ready,
  input  logic [DATA_W-1:0] rxsrc_data,
  input  logic              rxsrc_sof,
  input  logic              rxsrc_eof,
  input  logic              txsrc_valid,
  output logic              txsrc_ready,
  input  logic [DATA_W-1:0] txsrc_data,
  input  logic              txsrc_sof,
  input  logic              txsrc_eof,
  input  logic              play_valid,
  output logic              play_ready,
  input  logic [DATA_W-1:0] play_data,
  input  logic              play_sof,
  input  logic              play_eof,
  output logic              dma_rx_valid,
  input  logic              dma_rx_ready,
  output logic [DATA_W-1:0] dma_rx_data,
  output logic              dma_rx_sof,
  output logic              dma_rx_eof,
  output logic              net_tx_valid,
  input  logic              net_tx_ready,
  output logic [DATA_W-1:0] net_tx_data,
  output logic              net_tx_sof,
  output logic              net_tx_eof
);
  localparam int unsigned BEAT_W = DATA_W + 2;

  ls_sel_t                        sel_q;
  logic [NUM_SRC-1:0]             src_valid, src_ready;
  logic [NUM_SRC-1:0][BEAT_W-1:0] src_beat;
  logic                           a_push, b_push, a_room, b_room;
  logic [BEAT_W-1:0]              a_in, b_in, a_out, b_out;
  logic                           unused_bits;

  assign unused_bits = ^{bus_be, bus_addr[31:8], bus_wdata[31:2]};
  assign bus_ardy    = 1'b1;

  ls_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .offs  (bus_addr[7:0]),
    .wval  (bus_wdata[1:0]),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .rdata (bus_rdata),
    .drdy  (bus_drdy),
    .sel   (sel_q)
  );

  assign src_valid[SRC_NETRX] = net_rx_valid;
  assign src_valid[SRC_DMATX] = dma_tx_valid;
  assign src_valid[SRC_RXGEN] = rxsrc_valid;
  assign src_valid[SRC_TXGEN] = txsrc_valid;
  assign src_valid[SRC_PLAY]  = play_valid;
  assign src_beat[SRC_NETRX]  = {net_rx_sof, net_rx_eof, net_rx_data};
  assign src_beat[SRC_DMATX]  = {dma_tx_sof, dma_tx_eof, dma_tx_data};
  assign src_beat[SRC_RXGEN]  = {rxsrc_sof, rxsrc_eof, rxsrc_data};
  assign src_beat[SRC_TXGEN]  = {txsrc_sof, txsrc_eof, txsrc_data};
  assign src_beat[SRC_PLAY]   = {play_sof, play_eof, play_data};
  assign net_rx_ready = src_ready[SRC_NETRX];
  assign dma_tx_ready = src_ready[SRC_DMATX];
  assign rxsrc_ready  = src_ready[SRC_RXGEN];
  assign txsrc_ready  = src_ready[SRC_TXGEN];
  assign play_ready   = src_ready[SRC_PLAY];

  ls_route #(.W(BEAT_W), .BYPASS(BYPASS)) u_route (
    .src_valid (src_valid),
    .src_beat  (src_beat),
    .sel       (sel_q),
    .a_room    (a_room),
    .b_room    (b_room),
    .src_ready (src_ready),
    .a_push    (a_push),
    .a_beat    (a_in),
    .b_push    (b_push),
    .b_beat    (b_in)
  );

  ls_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) u_fifo_dmarx (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (a_push),
    .in_beat   (a_in),
    .room      (a_room),
    .out_valid (dma_rx_valid),
    .out_ready (dma_rx_ready),
    .out_beat  (a_out)
  );

  ls_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) u_fifo_nettx (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (b_push),
    .in_beat   (b_in),
    .room      (b_room),
    .out_valid (net_tx_valid),
    .out_ready (net_tx_ready),
    .out_beat  (b_out)
  );

  assign {dma_rx_sof, dma_rx_eof, dma_rx_data} = a_out;
  assign {net_tx_sof, net_tx_eof, net_tx_data} = b_out;
endmodule

// File: rtl/ls_checker.sv
module ls_checker
  import ls_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter bit          BYP = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_rd,
  input logic [31:0]  bus_addr,
  input logic         bus_drdy,
  input logic [31:0]  bus_rdata,
  input ls_sel_t      sel,
  input logic         rxsrc_ready,
  input logic         play_ready,
  input logic         dma_rx_valid,
  input logic         dma_rx_ready,
  input logic [W-1:0] dma_rx_data,
  input logic         net_tx_valid,
  input logic         net_tx_ready,
  input logic [W-1:0] net_tx_data
);
  logic unmapped;
  assign unmapped = !(bus_addr[7:0] inside {OFS_A, OFS_B, OFS_C, OFS_D});

  a_r3_drdy_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_drdy);
  a_r3_no_spurious_drdy: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_drdy);
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> (bus_rdata == 32'd0));
  a_r8_dmarx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_valid && !dma_rx_ready) |=> (dma_rx_valid && $stable(dma_rx_data)));
  a_r8_nettx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (net_tx_valid && !net_tx_ready) |=> (net_tx_valid && $stable(net_tx_data)));

  if (!BYP) begin : g_sel_checks
    a_r9_rxsrc_gated: assert property (@(posedge clk) disable iff (!rst_n)
      rxsrc_ready |-> (!sel.a && sel.c));
    a_r9_play_gated: assert property (@(posedge clk) disable iff (!rst_n)
      play_ready |-> (!sel.b && sel.d == 2'd2));
    a_r7_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!net_tx_valid && !sel.b && sel.d == 2'd3) |=> !net_tx_valid);
  end else begin : g_byp_checks
    a_r10_rxsrc_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rxsrc_ready);
  end
endmodule

bind loop_switch ls_checker #(.W(DATA_W), .BYP(BYPASS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_drdy     (bus_drdy),
  .bus_rdata    (bus_rdata),
  .sel          (sel_q),
  .rxsrc_ready  (rxsrc_ready),
  .play_ready   (play_ready),
  .dma_rx_valid (dma_rx_valid),
  .dma_rx_ready (dma_rx_ready),
  .dma_rx_data  (dma_rx_data),
  .net_tx_valid (net_tx_valid),
  .net_tx_ready (net_tx_ready),
  .net_tx_data  (net_tx_data)
);

// File: tb/loop_switch_bench.sv
`timescale 1ns/1ps
module loop_switch_bench;
  localparam int DW = 16;
  localparam int NONE = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  logic [31:0] bus_addr, bus_wdata, bus_rdata, byp_rdata;
  logic [3:0]  bus_be;
  logic        bus_wr, bus_rd, bus_ardy, bus_drdy, byp_ardy, byp_drdy;

  logic [4:0]    s_valid, s_sof, s_eof;
  logic [DW-1:0] s_data [5];
  logic [4:0]    s_ready;

  logic          k_valid [2];
  logic          k_ready [2];
  logic [DW-1:0] k_data  [2];
  logic          k_sof   [2];
  logic          k_eof   [2];

  loop_switch #(.DATA_W(DW), .FIFO_DEPTH(4), .BYPASS(1'b0)) u_loop_switch (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ardy(bus_ardy),
    .bus_rdata(bus_rdata), .bus_drdy(bus_drdy),
    .net_rx_valid(s_valid[0]), .net_rx_ready(s_ready[0]), .net_rx_data(s_data[0]),
    .net_rx_sof(s_sof[0]), .net_rx_eof(s_eof[0]),
    .dma_tx_valid(s_valid[1]), .dma_tx_ready(s_ready[1]), .dma_tx_data(s_data[1]),
    .dma_tx_sof(s_sof[1]), .dma_tx_eof(s_eof[1]),
    .rxsrc_valid(s_valid[2]), .rxsrc_ready(s_ready[2]), .rxsrc_data(s_data[2]),
    .rxsrc_sof(s_sof[2]), .rxsrc_eof(s_eof[2]),
    .txsrc_valid(s_valid[3]), .txsrc_ready(s_ready[3]), .txsrc_data(s_data[3]),
    .txsrc_sof(s_sof[3]), .txsrc_eof(s_eof[3]),
    .play_valid(s_valid[4]), .play_ready(s_ready[4]), .play_data(s_data[4]),
    .play_sof(s_sof[4]), .play_eof(s_eof[4]),
    .dma_rx_valid(k_valid[0]), .dma_rx_ready(k_ready[0]), .dma_rx_data(k_data[0]),
    .dma_rx_sof(k_sof[0]), .dma_rx_eof(k_eof[0]),
    .net_tx_valid(k_valid[1]), .net_tx_ready(k_ready[1]), .net_tx_data(k_data[1]),
    .net_tx_sof(k_sof[1]), .net_tx_eof(k_eof[1])
  );

  // bypass instance with its own stream signals
  logic          b_nrx_valid, b_nrx_ready, b_nrx_sof, b_nrx_eof;
  logic          b_dtx_valid, b_dtx_ready, b_dtx_sof, b_dtx_eof;
  logic          b_gen_valid, b_gen_ready, b_txg_ready, b_ply_ready;
  logic [DW-1:0] b_nrx_data, b_dtx_data, b_drx_data, b_ntx_data;
  logic          b_drx_valid, b_drx_sof, b_drx_eof, b_ntx_valid, b_ntx_sof, b_ntx_eof;

  loop_switch #(.DATA_W(DW), .FIFO_DEPTH(4), .BYPASS(1'b1)) u_loop_switch_byp (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ardy(byp_ardy),
    .bus_rdata(byp_rdata), .bus_drdy(byp_drdy),
    .net_rx_valid(b_nrx_valid), .net_rx_ready(b_nrx_ready), .net_rx_data(b_nrx_data),
    .net_rx_sof(b_nrx_sof), .net_rx_eof(b_nrx_eof),
    .dma_tx_valid(b_dtx_valid), .dma_tx_ready(b_dtx_ready), .dma_tx_data(b_dtx_data),
    .dma_tx_sof(b_dtx_sof), .dma_tx_eof(b_dtx_eof),
    .rxsrc_valid(b_gen_valid), .rxsrc_ready(b_gen_ready), .rxsrc_data(16'h0),
    .rxsrc_sof(1'b0), .rxsrc_eof(1'b0),
    .txsrc_valid(b_gen_valid), .txsrc_ready(b_txg_ready), .txsrc_data(16'h0),
    .txsrc_sof(1'b0), .txsrc_eof(1'b0),
    .play_valid(b_gen_valid), .play_ready(b_ply_ready), .play_data(16'h0),
    .play_sof(1'b0), .play_eof(1'b0),
    .dma_rx_valid(b_drx_valid), .dma_rx_ready(1'b1), .dma_rx_data(b_drx_data),
    .dma_rx_sof(b_drx_sof), .dma_rx_eof(b_drx_eof),
    .net_tx_valid(b_ntx_valid), .net_tx_ready(1'b1), .net_tx_data(b_ntx_data),
    .net_tx_sof(b_ntx_sof), .net_tx_eof(b_ntx_eof)
  );

  int  vectors = 0;
  int  miscompares = 0;
  int  cyc = 0;
  int  seq [5];
  int  start [5];
  bit  fire [5];
  int  rx_seq [2];
  int  exp_src [2];
  bit  hold_pend [2];
  logic [DW-1:0] held [2];
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] beat_data(input int id, input int sq);
    return {3'(id), 13'(sq)};
  endfunction

  task automatic drive_sources(input bit on);
    for (int s = 0; s < 5; s++) begin
      s_valid[s] = on;
      s_data[s]  = beat_data(s, seq[s]);
      s_sof[s]   = (seq[s] % 4) == 0;
      s_eof[s]   = (seq[s] % 4) == 3;
    end
  endtask

  task automatic bus_write(input logic [7:0] offs, input int val);
    @(negedge clk);
    bus_addr  = 32'h5A00_0000 | 32'(offs);
    bus_wdata = {30'h3FFF_FFFF, 2'(val)};
    bus_be    = 4'h0;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] offs, input int exp, input string req);
    @(negedge clk);
    bus_addr = 32'hC300_0000 | 32'(offs);
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    chk(bus_drdy == 1'b1 && bus_rdata == 32'(exp), req, {bus_drdy, bus_rdata}, {1'b1, 32'(exp)});
  endtask

  task automatic run_cycles(input int n, input bit on);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int s = 0; s < 5; s++) if (fire[s]) seq[s]++;
      drive_sources(on);
      k_ready[0] = (cyc % 3) != 0;
      k_ready[1] = (cyc % 5) != 1;
      cyc++;
      for (int k = 0; k < 2; k++)
        if (hold_pend[k])
          chk(k_valid[k] && k_data[k] == held[k], "R8 stalled output stable", k_data[k], held[k]);
      #1;
      for (int s = 0; s < 5; s++) begin
        fire[s] = s_valid[s] && s_ready[s];
        if (exp_src[0] != s && exp_src[1] != s)
          chk(s_ready[s] == 1'b0, "R9 unselected ready low", s_ready[s], 0);
      end
      for (int k = 0; k < 2; k++) begin
        if (exp_src[k] == NONE)
          chk(k_valid[k] == 1'b0, "R7 reserved code idle", k_valid[k], 0);
        else if (k_valid[k] && k_ready[k]) begin
          chk(k_data[k] == beat_data(exp_src[k], rx_seq[k]),
              (k == 0) ? "R4 R5 dma_rx route/order" : "R6 R7 net_tx route/order",
              k_data[k], beat_data(exp_src[k], rx_seq[k]));
          chk(k_sof[k] == ((rx_seq[k] % 4) == 0) && k_eof[k] == ((rx_seq[k] % 4) == 3),
              "R8 frame flags", {k_sof[k], k_eof[k]},
              {((rx_seq[k] % 4) == 0), ((rx_seq[k] % 4) == 3)});
          rx_seq[k]++;
        end
        hold_pend[k] = k_valid[k] && !k_ready[k];
        held[k]      = k_data[k];
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_be = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    k_ready[0] = 1'b1; k_ready[1] = 1'b1;
    b_nrx_valid = 1'b0; b_nrx_data = '0; b_nrx_sof = 1'b0; b_nrx_eof = 1'b0;
    b_dtx_valid = 1'b0; b_dtx_data = '0; b_dtx_sof = 1'b0; b_dtx_eof = 1'b0;
    b_gen_valid = 1'b0;
    for (int s = 0; s < 5; s++) begin seq[s] = 0; fire[s] = 1'b0; end
    drive_sources(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(k_valid[0] == 1'b0 && k_valid[1] == 1'b0, "R1 sinks idle after reset",
        {k_valid[0], k_valid[1]}, 0);
    chk(bus_ardy == 1'b1 && bus_drdy == 1'b0, "R3 ardy high, no drdy", {bus_ardy, bus_drdy}, 2);
    bus_read(8'h00, 0, "R1 reset select A");
    bus_read(8'h04, 0, "R1 reset select B");
    bus_read(8'h08, 0, "R1 reset select C");
    bus_read(8'h0C, 0, "R1 reset select D");
    bus_write(8'h10, 3);
    bus_read(8'h10, 0, "R3 unmapped reads zero");
    bus_read(8'h40, 0, "R3 unmapped reads zero");
    bus_read(8'h0C, 0, "R3 unmapped write no effect");

    // sweep all routing combinations
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
          for (int d = 0; d < 4; d++) begin
            bus_write(8'h00, a);
            bus_write(8'h04, b);
            bus_write(8'h08, c);
            bus_write(8'h0C, d);
            bus_read(8'h00, a, "R2 select A readback");
            bus_read(8'h04, b, "R2 select B readback");
            bus_read(8'h08, c, "R2 select C readback");
            bus_read(8'h0C, d, "R2 select D readback");
            exp_src[0] = a ? 1 : (c ? 2 : 0);
            exp_src[1] = b ? 0 : ((d == 0) ? 1 : (d == 1) ? 3 : (d == 2) ? 4 : NONE);
            for (int s = 0; s < 5; s++) start[s] = seq[s];
            for (int k = 0; k < 2; k++) begin
              rx_seq[k]    = (exp_src[k] == NONE) ? 0 : start[exp_src[k]];
              hold_pend[k] = 1'b0;
            end
            run_cycles(40, 1'b1);
            run_cycles(20, 1'b0);
            for (int k = 0; k < 2; k++)
              if (exp_src[k] != NONE)
                chk(rx_seq[k] == seq[exp_src[k]], "R9 no beat lost or duplicated",
                    rx_seq[k], seq[exp_src[k]]);
            for (int s = 0; s < 5; s++)
              if (exp_src[0] != s && exp_src[1] != s)
                chk(seq[s] == start[s], "R9 unselected source not consumed", seq[s], start[s]);
              else
                chk(seq[s] > start[s], "R9 selected source consumed", seq[s], start[s]);
          end

    // R10 bypass: registers hold A=1 B=1 C=1 D=3 here and must be ignored
    @(negedge clk);
    b_nrx_valid = 1'b1; b_nrx_data = 16'hBEEF; b_nrx_sof = 1'b1; b_nrx_eof = 1'b0;
    b_dtx_valid = 1'b1; b_dtx_data = 16'h1357; b_dtx_sof = 1'b0; b_dtx_eof = 1'b1;
    b_gen_valid = 1'b1;
    #1;
    chk(b_nrx_ready && b_dtx_ready, "R10 bypass sources ready", {b_nrx_ready, b_dtx_ready}, 3);
    chk(!b_gen_ready && !b_txg_ready && !b_ply_ready, "R10 bypass traffic sources held",
        {b_gen_ready, b_txg_ready, b_ply_ready}, 0);
    @(negedge clk);
    b_nrx_valid = 1'b0; b_dtx_valid = 1'b0; b_gen_valid = 1'b0;
    chk(b_drx_valid && b_drx_data == 16'hBEEF && b_drx_sof && !b_drx_eof,
        "R10 bypass net rx to dma rx", {b_drx_valid, b_drx_data}, {1'b1, 16'hBEEF});
    chk(b_ntx_valid && b_ntx_data == 16'h1357 && !b_ntx_sof && b_ntx_eof,
        "R10 bypass dma tx to net tx", {b_ntx_valid, b_ntx_data}, {1'b1, 16'h1357});
    @(negedge clk);
    chk(!b_drx_valid && !b_ntx_valid, "R10 bypass single beat each",
        {b_drx_valid, b_ntx_valid}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule